// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a register-in, register-out synchronous SRAM of the kind placed beside a processor as a second-level cache. Addresses are started by either of two active-low strobes, one meant for the processor and one for the cache controller. An internal two-bit counter then walks a four-beat burst, in linear or interleaved order, each time the active-low advance input is low. Reads return one clock after the access is registered. Writes are gated per 8-bit lane.

Tying the processor strobe high, the controller strobe low and advance high turns the part into a plain pipelined RAM. In that mode every cycle acts on the address presented with it.

A sleep input deselects the device and freezes the array. A four-state controller manages sleep.

- RUN allows accesses.
- RUN moves to DRAIN when sleep rises.
- DRAIN moves to SLEEP if sleep is still high, or to WAKE if it has dropped.
- SLEEP moves to WAKE when sleep falls.
- WAKE counts `RECOVER_CYC` cycles and then moves to RUN. It moves back to DRAIN if sleep rises again.

Strobes or writes seen during WAKE are ignored and set a sticky violation flag.

`ADDR_W` sets the array depth. The 32-bit-wide, 32K-word configuration uses `ADDR_W = 15`. The default is smaller.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rvalid` = 0, `rdata` = 0 and `wake_viol` = 0, and no access takes place until a strobe is accepted.
- R2: A read is registered at clock edge k. Its word appears on `rdata` with `rvalid` = 1 after edge k+1.
- R3: `byte_we[i]` = 1 writes only bits 8i+7..8i of the addressed word. Other lanes keep their contents.
- R4: An access with any `byte_we` bit set is a write. After the edge that follows it, `rvalid` = 0 and `rdata` = 0.
- R5: `ads_cpu_n` = 0 starts a burst only when `chip_en` = 1. With `chip_en` = 0 it is ignored, and any running burst continues unchanged.
- R6: `ads_ctl_n` = 0 with `chip_en` = 1 starts a burst. With `chip_en` = 0 it ends the burst, and that cycle performs no access.
- R7: With `lin_order` = 1, the low two address bits of each beat are (start low bits + beat count) mod 4.
- R8: With `lin_order` = 0, the low two address bits of each beat are start low bits XOR beat count.
- R9: `adv_n` = 0 during a burst steps the beat count, which wraps after four beats. With `adv_n` = 1 the same address is accessed again.
- R10: With `ads_cpu_n` = 1, `ads_ctl_n` = 0 and `adv_n` = 1 held every cycle, each cycle accesses the address presented in that cycle, one result per cycle.
- R11: While `sleep_req` = 1, no read or write is performed, `rvalid` is 0 from the second edge on, and the array keeps its contents.
- R12: After sleep is released, the device spends `RECOVER_CYC` cycles in WAKE. Any strobe or write in that time is ignored and sets `wake_viol`, which stays set until reset.
- R13: The sleep controller follows RUN→DRAIN→{SLEEP, WAKE}, SLEEP→WAKE, WAKE→{RUN, DRAIN}. A one-cycle sleep pulse still passes through WAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| chip_en | input | 1 | Chip enable, active high |
| lin_order | input | 1 | 1 = linear burst, 0 = interleaved |
| byte_we | input | DATA_W/8 | Per-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| sleep_req | input | 1 | Sleep request |
| rdata | output | DATA_W | Registered read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |
| wake_viol | output | 1 | Sticky flag: access attempted during recovery |

## Verification
A wrong beat counter or base register shows up as a wrong word on `rdata` exactly two edges after the beat that used it. The table therefore follows each burst beat by beat with distinct data in every word. A sleep controller stuck in the wrong state shows up either as an accepted access during sleep or recovery, or as a lost access after recovery. The first case makes `rvalid` rise two edges later. The second makes the expected retained word fail to appear. A missing or spurious violation is seen on `wake_viol` one edge after the offending strobe.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        SL_RUN   = 2'd0,
        SL_DRAIN = 2'd1,
        SL_SLEEP = 2'd2,
        SL_WAKE  = 2'd3
    } sleep_state_t;

endpackage

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sram_pkg::*;
#(
    parameter int RECOVER_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_req,
    input  logic         access_try,
    output logic         run_ok,
    output sleep_state_t state,
    output logic         viol
);
    localparam int CW = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

    sleep_state_t nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          in_wake;

    // next-state logic
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            SL_RUN: begin
                if (sleep_req) nxt = SL_DRAIN;
            end
            SL_DRAIN: begin
                cnt_nxt = '0;
                nxt     = sleep_req ? SL_SLEEP : SL_WAKE;
            end
            SL_SLEEP: begin
                cnt_nxt = '0;
                if (!sleep_req) nxt = SL_WAKE;
            end
            SL_WAKE: begin
                if (sleep_req) begin
                    nxt = SL_DRAIN;
                end else if (cnt == LAST) begin
                    nxt = SL_RUN;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: nxt = SL_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SL_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        run_ok  = 1'b0;
        in_wake = 1'b0;
        unique case (state)
            SL_RUN:   run_ok  = 1'b1;
            SL_WAKE:  in_wake = 1'b1;
            default:  run_ok  = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  viol <= 1'b0;
        else if (in_wake && access_try) viol <= 1'b1;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              ads_cpu_n,
    input  logic              ads_ctl_n,
    input  logic              adv_n,
    input  logic              chip_en,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr
);
    logic              active;
    logic [ADDR_W-1:0] base;
    logic [1:0]        cnt;

    logic              cpu_go;
    logic              ctl_go;
    logic              desel;
    logic              start;
    logic              step;
    logic [1:0]        cnt_use;
    logic [ADDR_W-1:0] base_use;
    logic [1:0]        low;

    always_comb begin
        cpu_go   = gate && !ads_cpu_n && chip_en;
        ctl_go   = gate && !ads_ctl_n && chip_en;
        desel    = gate && !ads_ctl_n && !chip_en;
        start    = cpu_go || ctl_go;
        step     = active && !adv_n;
        base_use = start ? addr : base;
        if (start)     cnt_use = 2'd0;
        else if (step) cnt_use = cnt + 2'd1;
        else           cnt_use = cnt;
        if (lin_order) low = base_use[1:0] + cnt_use;
        else           low = base_use[1:0] ^ cnt_use;
        acc_addr  = {base_use[ADDR_W-1:2], low};
        acc_valid = start || (gate && active && !desel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            cnt    <= 2'd0;
        end else if (!gate || desel) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            base   <= addr;
            cnt    <= 2'd0;
        end else if (step) begin
            cnt    <= cnt + 2'd1;
        end
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_valid,
    input  logic [ADDR_W-1:0]   a_addr,
    input  logic [DATA_W/8-1:0] a_we,
    input  logic [DATA_W-1:0]   a_wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);
    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic              s_rd;
    logic [LANES-1:0]  s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;

    // input register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_rd    <= 1'b0;
            s_we    <= '0;
            s_addr  <= '0;
            s_wdata <= '0;
        end else begin
            s_rd    <= a_valid && (a_we == '0);
            s_we    <= a_valid ? a_we : '0;
            s_addr  <= a_addr;
            s_wdata <= a_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= s_rd;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (s_we[g]) lane_mem[s_addr] <= s_wdata[g*8 +: 8];
        end

        // output register stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rd_q <= 8'd0;
            else if (s_rd) rd_q <= lane_mem[s_addr];
            else           rd_q <= 8'd0;
        end

        assign rdata[g*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int RECOVER_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ads_cpu_n,
    input  logic                ads_ctl_n,
    input  logic                adv_n,
    input  logic                chip_en,
    input  logic                lin_order,
    input  logic [DATA_W/8-1:0] byte_we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                sleep_req,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid,
    output logic                wake_viol
);
    sleep_state_t      sl_state;
    logic              run_ok;
    logic              gate;
    logic              access_try;
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;

    assign access_try = !ads_cpu_n || !ads_ctl_n || (byte_we != '0);
    assign gate       = run_ok && !sleep_req;

    sleep_ctrl #(.RECOVER_CYC(RECOVER_CYC)) u_sleep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .access_try (access_try),
        .run_ok     (run_ok),
        .state      (sl_state),
        .viol       (wake_viol)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .ads_cpu_n (ads_cpu_n),
        .ads_ctl_n (ads_ctl_n),
        .adv_n     (adv_n),
        .chip_en   (chip_en),
        .lin_order (lin_order),
        .addr      (addr),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_valid (acc_valid),
        .a_addr  (acc_addr),
        .a_we    (byte_we),
        .a_wdata (wdata),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

endmodule

// File: rtl/sram_checker.sv
module sram_checker
    import sram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ads_cpu_n,
    input logic                ads_ctl_n,
    input logic                chip_en,
    input logic [DATA_W/8-1:0] byte_we,
    input logic                sleep_req,
    input logic                rvalid,
    input logic                wake_viol,
    input logic                gate,
    input sleep_state_t        sl_state
);
    assert_write_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !ads_ctl_n && chip_en && (byte_we != '0)) |=> ##1 !rvalid);

    assert_sleep_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> ##1 !rvalid);

    assert_viol_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_viol |=> wake_viol);

    assert_wake_try_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_state == SL_WAKE && (!ads_cpu_n || !ads_ctl_n || (byte_we != '0))) |=> wake_viol);

    assert_sleep_via_drain_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_state == SL_SLEEP) |-> ($past(sl_state) == SL_DRAIN || $past(sl_state) == SL_SLEEP));

endmodule

bind sync_burst_sram sram_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_cpu_n (ads_cpu_n),
    .ads_ctl_n (ads_ctl_n),
    .chip_en   (chip_en),
    .byte_we   (byte_we),
    .sleep_req (sleep_req),
    .rvalid    (rvalid),
    .wake_viol (wake_viol),
    .gate      (gate),
    .sl_state  (sl_state)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int RC = 4;
    localparam int NV = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ads_cpu_n = 1'b1;
    logic          ads_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          chip_en = 1'b1;
    logic          lin_order = 1'b1;
    logic [3:0]    byte_we = 4'h0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          sleep_req = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          wake_viol;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .RECOVER_CYC(RC)) u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n),
        .adv_n(adv_n), .chip_en(chip_en), .lin_order(lin_order), .byte_we(byte_we),
        .addr(addr), .wdata(wdata), .sleep_req(sleep_req),
        .rdata(rdata), .rvalid(rvalid), .wake_viol(wake_viol)
    );

    // {cpu_n, ctl_n, adv_n, ce, lin, we, addr, wdata, exp_valid, exp_data, req}
    function automatic logic [87:0] mk(input logic cn, input logic tn, input logic vn,
                                       input logic ce, input logic ln, input logic [3:0] we,
                                       input logic [9:0] a, input logic [31:0] wd,
                                       input logic ev, input logic [31:0] ed,
                                       input logic [3:0] rq);
        return {cn, tn, vn, ce, ln, we, a, wd, ev, ed, rq};
    endfunction

    // expected fields give the output seen after the row's edge (result of the previous row)
    localparam logic [87:0] VEC [NV] = '{
        mk(1,0,1,1,1,4'hF,10'h010,32'h11111111, 0,32'h0,        4'd10), // R10 write
        mk(1,0,1,1,1,4'hF,10'h011,32'h22222222, 0,32'h0,        4'd4),  // R4
        mk(1,0,1,1,1,4'hF,10'h012,32'h33333333, 0,32'h0,        4'd4),  // R4
        mk(1,0,1,1,1,4'hF,10'h013,32'h44444444, 0,32'h0,        4'd4),  // R4
        mk(1,0,1,1,1,4'h0,10'h010,32'h0,        0,32'h0,        4'd4),  // R4 read
        mk(1,0,1,1,1,4'h0,10'h013,32'h0,        1,32'h11111111, 4'd2),  // R2
        mk(1,0,1,1,1,4'h1,10'h012,32'hFFFFFFAA, 1,32'h44444444, 4'd10), // R10, R3 write lane 0
        mk(1,0,1,1,1,4'h0,10'h012,32'h0,        0,32'h0,        4'd4),  // R4
        mk(0,1,1,1,1,4'h0,10'h011,32'h0,        1,32'h333333AA, 4'd3),  // R3, linear start
        mk(1,1,0,1,1,4'h0,10'h000,32'h0,        1,32'h22222222, 4'd7),  // R7 ->0x12
        mk(1,1,0,1,1,4'h0,10'h000,32'h0,        1,32'h333333AA, 4'd7),  // R7 ->0x13
        mk(1,1,0,1,1,4'h0,10'h000,32'h0,        1,32'h44444444, 4'd7),  // R7 ->0x10
        mk(1,1,0,1,1,4'h0,10'h000,32'h0,        1,32'h11111111, 4'd9),  // R9 wrap ->0x11
        mk(1,1,1,1,1,4'h0,10'h000,32'h0,        1,32'h22222222, 4'd9),  // R9 hold 0x11
        mk(0,1,1,1,0,4'h0,10'h013,32'h0,        1,32'h22222222, 4'd9),  // R8 start 0x13
        mk(1,1,0,1,0,4'h0,10'h000,32'h0,        1,32'h44444444, 4'd8),  // R8 ->0x12
        mk(1,1,0,1,0,4'h0,10'h000,32'h0,        1,32'h333333AA, 4'd8),  // R8 ->0x11
        mk(1,1,0,1,0,4'h0,10'h000,32'h0,        1,32'h22222222, 4'd8),  // R8 ->0x10
        mk(0,1,1,0,0,4'h0,10'h012,32'h0,        1,32'h11111111, 4'd5),  // R5 ignored, stays 0x10
        mk(1,0,1,0,1,4'h0,10'h012,32'h0,        1,32'h11111111, 4'd6),  // R6 deselect
        mk(1,1,1,1,1,4'h0,10'h000,32'h0,        0,32'h0,        4'd6),  // R6 no access
        mk(1,1,1,1,1,4'h0,10'h000,32'h0,        0,32'h0,        4'd1)   // R1 idle stays idle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic cn, input logic tn, input logic vn, input logic ce,
                         input logic ln, input logic [3:0] we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic sl);
        ads_cpu_n = cn; ads_ctl_n = tn; adv_n = vn; chip_en = ce; lin_order = ln;
        byte_we = we; addr = a; wdata = wd; sleep_req = sl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input logic sl);
        drive(1, 1, 1, 1, 1, 4'h0, '0, '0, sl);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        chk("R1 wake_viol", {31'd0, wake_viol}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [87:0] v;
            v = VEC[i];
            drive(v[87], v[86], v[85], v[84], v[83], v[82:79], v[78:69], v[68:37], 1'b0);
            chk($sformatf("R%0d row %0d rvalid", v[3:0], i), {31'd0, rvalid}, {31'd0, v[36]});
            chk($sformatf("R%0d row %0d rdata", v[3:0], i), rdata, v[35:4]);
        end

        // R11: sleep with a write attempt to 0x010, which must be blocked
        drive(1, 0, 1, 1, 1, 4'hF, 10'h010, 32'hDEADBEEF, 1'b1);
        idle(1'b1);
        chk("R11 rvalid in sleep", {31'd0, rvalid}, 32'd0);
        idle(1'b1);
        chk("R11 viol not set by sleep", {31'd0, wake_viol}, 32'd0);
        idle(1'b0);                                   // SLEEP -> WAKE
        drive(1, 0, 1, 1, 1, 4'h0, 10'h010, '0, 1'b0); // R12 read during WAKE
        chk("R12 viol set", {31'd0, wake_viol}, 32'd1);
        idle(1'b0);
        chk("R12 ignored read", {31'd0, rvalid}, 32'd0);
        repeat (RC) idle(1'b0);
        drive(1, 0, 1, 1, 1, 4'h0, 10'h010, '0, 1'b0);
        idle(1'b0);
        chk("R11 contents kept rvalid", {31'd0, rvalid}, 32'd1);
        chk("R11 contents kept rdata", rdata, 32'h11111111);
        chk("R12 viol sticky", {31'd0, wake_viol}, 32'd1);

        // R13: one-cycle pulse goes DRAIN -> WAKE, so a strobe then still flags
        do_reset();
        chk("R1 viol cleared", {31'd0, wake_viol}, 32'd0);
        idle(1'b1);                                    // RUN -> DRAIN
        drive(1, 0, 1, 1, 1, 4'h0, 10'h011, '0, 1'b0);  // DRAIN -> WAKE, blocked
        chk("R13 drain no flag", {31'd0, wake_viol}, 32'd0);
        drive(1, 0, 1, 1, 1, 4'h0, 10'h011, '0, 1'b0);  // in WAKE
        chk("R13 pulse wake flag", {31'd0, wake_viol}, 32'd1);
        chk("R13 drain access blocked", {31'd0, rvalid}, 32'd0);

        finish_run();
    end

endmodule